// File: doc/BRIEF.md
# Split-Address Permission Monitor

This block sits beside a bus and watches every access that lands in one protected address window. A programmable split point divides the window into a lower region and an upper region. Each region carries its own read, write and execute enables. An access is judged against the enables of the region it hits. Instruction fetches are checked against execute, other writes against write, and other reads against read. Accesses that fall outside the window are never judged. The monitor only detects and reports violations; it does not stop the offending transfer.

On a violation the monitor raises a pending flag. It also records the location of the fault inside the window, the access direction, whether it was a fetch, and a sideband subtype bit. The record is frozen until software clears the flag, so later faults do not overwrite the first one. An interrupt output is the pending flag gated by an enable bit. A sticky lock bit freezes the split point and the enables until reset. Software reaches all state through a four-entry register port. Register writes and observed accesses take effect at the next rising clock edge. Reads are combinational.

Top module: `split_perm_mon`

## Requirements
- R1: An access whose word offset in the window is below the configured split offset is judged by the lower-region enables, and one at or above it by the upper-region enables. An access below `WIN_LO` or beyond `WIN_LO+WIN_BYTES-1` never causes a fault.
- R2: A fetch (`acc_fetch`=1) needs the execute enable. Otherwise a write needs the write enable and a read needs the read enable. An access whose needed enable is 1 causes no fault.
- R3: Register 1 (config) holds the read, write and execute enables of the lower region in bits 0, 1 and 2. It holds the same enables of the upper region in bits 3, 4 and 5. The split point, as a word offset from `WIN_LO`, sits in bits [16:6]. An accepted write reads back unchanged one cycle later.
- R4: A config write whose split offset is not below the window size in words (1024 by default) is discarded whole, and the previous config stays in place. The offset 1023 is accepted.
- R5: Writing register 0 with bit 0 set makes the lock bit 1. The lock bit then stays 1 until reset, and writes with bit 0 clear have no effect.
- R6: While the lock bit is 1, config writes are discarded. The control register (2) can still be written.
- R7: Register 2 bit 2 is the pending flag, and a violation sets it whatever the enable bit (bit 0) holds. `irq` is high exactly when both pending and enable are 1.
- R8: While the clear bit (register 2 bit 1) holds 1, the pending flag is 0 and no violation sets it. Once the clear bit is written back to 0, a new violation sets the flag again.
- R9: Register 3 records the first violation while the flag is clear. Bits [11:2] hold the byte offset of the faulting word within the window, bit 29 the fetch flag, bit 30 the subtype and bit 31 the write direction. The record does not change while the flag stays pending.
- R10: After reset the lock is 0 and every enable is 1 with split offset 0, so config reads 0x3F. The enable, clear and pending bits are all 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register select: 0 lock, 1 config, 2 control, 3 fault record |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_sub | input | 1 | Sideband subtype bit recorded with a fault |
| irq | output | 1 | Interrupt: pending and enabled |

## Verification
The bench probes the region boundary on both sides of the split. A design that used the wrong comparison there would judge the word at the split by the lower-region enables. It also probes the words just outside both window edges, where a bounds error turns those accesses into spurious faults. It checks that a second violation leaves the first record intact and that the clear bit holds the flag down for as long as it stays set; a design that overwrote the record or cleared on a single pulse would show different status or control readbacks. It covers a split offset of exactly the window size, which must be refused, and a lock bit written back to zero, which must stay set. It also checks that config writes are dropped under lock while the control register stays writable.

// File: rtl/spm_pkg.sv
package spm_pkg;

    // Per-region enables; bit 0 read, bit 1 write, bit 2 execute.
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    localparam logic [1:0] SEL_LOCK = 2'd0;
    localparam logic [1:0] SEL_CFG  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam int CFG_LO_LSB    = 0;
    localparam int CFG_HI_LSB    = 3;
    localparam int CFG_SPLIT_LSB = 6;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_CLR  = 1;
    localparam int CTRL_PEND = 2;

    localparam int ST_FETCH = 29;
    localparam int ST_SUB   = 30;
    localparam int ST_WRITE = 31;

    // Which enable an access needs: fetch > write > read.
    function automatic logic access_ok(perm_t p, logic is_wr, logic is_fx);
        if (is_fx)      return p.x;
        else if (is_wr) return p.w;
        else            return p.r;
    endfunction

endpackage

// File: rtl/spm_cfg.sv
module spm_cfg
    import spm_pkg::*;
#(
    parameter int SPLIT_W = 11,
    parameter int WORDS   = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               lock_wr,
    input  logic               lock_bit,
    input  logic [SPLIT_W-1:0] new_split,
    input  perm_t              new_lo,
    input  perm_t              new_hi,
    output logic               locked,
    output perm_t              lo_perm,
    output perm_t              hi_perm,
    output logic [SPLIT_W-1:0] split_off
);

    localparam logic [31:0] WORDS_V = 32'(WORDS);

    typedef struct packed {
        logic               lock;
        perm_t              lo;
        perm_t              hi;
        logic [SPLIT_W-1:0] split;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic split_in_range;

    always_comb begin
        split_in_range = (32'(new_split) < WORDS_V);
        cfg_d = cfg_q;
        if (lock_wr && lock_bit) begin
            cfg_d.lock = 1'b1;
        end
        if (cfg_wr && !cfg_q.lock && split_in_range) begin
            cfg_d.lo    = new_lo;
            cfg_d.hi    = new_hi;
            cfg_d.split = new_split;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.lock  <= 1'b0;
            cfg_q.lo    <= '1;
            cfg_q.hi    <= '1;
            cfg_q.split <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign locked    = cfg_q.lock;
    assign lo_perm   = cfg_q.lo;
    assign hi_perm   = cfg_q.hi;
    assign split_off = cfg_q.split;

endmodule

// File: rtl/spm_check.sv
module spm_check
    import spm_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_LO    = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0000_1000,
    parameter int                OFF_W     = 10,
    parameter int                SPLIT_W   = OFF_W + 1
) (
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               acc_write,
    input  logic               acc_fetch,
    input  perm_t              lo_perm,
    input  perm_t              hi_perm,
    input  logic [SPLIT_W-1:0] split_off,
    output logic               viol,
    output logic [OFF_W-1:0]   word_off
);

    logic [ADDR_W-1:0] rel;
    logic              in_win;
    logic              upper;
    perm_t             sel_perm;

    always_comb begin
        // Unsigned wrap makes one compare cover both window edges.
        rel      = acc_addr - WIN_LO;
        in_win   = (rel < WIN_BYTES);
        word_off = rel[OFF_W+1:2];
        upper    = ({1'b0, word_off} >= split_off);
        sel_perm = upper ? hi_perm : lo_perm;
        viol     = acc_valid && in_win && !access_ok(sel_perm, acc_write, acc_fetch);
    end

endmodule

// File: rtl/spm_fault.sv
module spm_fault #(
    parameter int OFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             en_bit,
    input  logic             clr_bit,
    input  logic             viol,
    input  logic [OFF_W-1:0] word_off,
    input  logic             acc_write,
    input  logic             acc_fetch,
    input  logic             acc_sub,
    output logic             irq_en,
    output logic             clr_held,
    output logic             pending,
    output logic [OFF_W-1:0] st_off,
    output logic             st_write,
    output logic             st_fetch,
    output logic             st_sub
);

    typedef struct packed {
        logic             en;
        logic             clr;
        logic             pend;
        logic [OFF_W-1:0] off;
        logic             wr;
        logic             fx;
        logic             sub;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (ctrl_wr) begin
            flt_d.en  = en_bit;
            flt_d.clr = clr_bit;
        end
        if (flt_d.clr) begin
            flt_d.pend = 1'b0;
        end else if (viol) begin
            flt_d.pend = 1'b1;
            if (!flt_q.pend) begin
                flt_d.off = word_off;
                flt_d.wr  = acc_write;
                flt_d.fx  = acc_fetch;
                flt_d.sub = acc_sub;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign irq_en   = flt_q.en;
    assign clr_held = flt_q.clr;
    assign pending  = flt_q.pend;
    assign st_off   = flt_q.off;
    assign st_write = flt_q.wr;
    assign st_fetch = flt_q.fx;
    assign st_sub   = flt_q.sub;

endmodule

// File: rtl/split_perm_mon.sv
module split_perm_mon
    import spm_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_LO    = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_sub,
    output logic              irq
);

    localparam int WORDS   = int'(WIN_BYTES / 4);
    localparam int OFF_W   = $clog2(WORDS);
    localparam int SPLIT_W = OFF_W + 1;
    localparam int USED_W  = CFG_SPLIT_LSB + SPLIT_W;

    logic               locked;
    perm_t              lo_perm, hi_perm;
    logic [SPLIT_W-1:0] split_off;
    logic               viol;
    logic [OFF_W-1:0]   word_off;
    logic               irq_en, clr_held, pending;
    logic [OFF_W-1:0]   st_off;
    logic               st_write, st_fetch, st_sub;
    logic               cfg_wr, lock_wr, ctrl_wr;
    logic               unused_wd;

    assign cfg_wr    = reg_we && (reg_sel == SEL_CFG);
    assign lock_wr   = reg_we && (reg_sel == SEL_LOCK);
    assign ctrl_wr   = reg_we && (reg_sel == SEL_CTRL);
    assign unused_wd = ^reg_wdata[31:USED_W];

    spm_cfg #(
        .SPLIT_W (SPLIT_W),
        .WORDS   (WORDS)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .lock_wr   (lock_wr),
        .lock_bit  (reg_wdata[0]),
        .new_split (reg_wdata[CFG_SPLIT_LSB +: SPLIT_W]),
        .new_lo    (perm_t'(reg_wdata[CFG_LO_LSB +: 3])),
        .new_hi    (perm_t'(reg_wdata[CFG_HI_LSB +: 3])),
        .locked    (locked),
        .lo_perm   (lo_perm),
        .hi_perm   (hi_perm),
        .split_off (split_off)
    );

    spm_check #(
        .ADDR_W    (ADDR_W),
        .WIN_LO    (WIN_LO),
        .WIN_BYTES (WIN_BYTES),
        .OFF_W     (OFF_W),
        .SPLIT_W   (SPLIT_W)
    ) u_check (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .acc_fetch (acc_fetch),
        .lo_perm   (lo_perm),
        .hi_perm   (hi_perm),
        .split_off (split_off),
        .viol      (viol),
        .word_off  (word_off)
    );

    spm_fault #(
        .OFF_W (OFF_W)
    ) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .en_bit    (reg_wdata[CTRL_EN]),
        .clr_bit   (reg_wdata[CTRL_CLR]),
        .viol      (viol),
        .word_off  (word_off),
        .acc_write (acc_write),
        .acc_fetch (acc_fetch),
        .acc_sub   (acc_sub),
        .irq_en    (irq_en),
        .clr_held  (clr_held),
        .pending   (pending),
        .st_off    (st_off),
        .st_write  (st_write),
        .st_fetch  (st_fetch),
        .st_sub    (st_sub)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_LOCK: reg_rdata[0] = locked;
            SEL_CFG: begin
                reg_rdata[CFG_LO_LSB +: 3]          = lo_perm;
                reg_rdata[CFG_HI_LSB +: 3]          = hi_perm;
                reg_rdata[CFG_SPLIT_LSB +: SPLIT_W] = split_off;
            end
            SEL_CTRL: begin
                reg_rdata[CTRL_EN]   = irq_en;
                reg_rdata[CTRL_CLR]  = clr_held;
                reg_rdata[CTRL_PEND] = pending;
            end
            default: begin
                reg_rdata[OFF_W+1:2] = st_off;
                reg_rdata[ST_FETCH]  = st_fetch;
                reg_rdata[ST_SUB]    = st_sub;
                reg_rdata[ST_WRITE]  = st_write;
            end
        endcase
    end

    assign irq = pending && irq_en;

endmodule

// File: rtl/spm_chk.sv
module spm_chk #(
    parameter int SPLIT_W = 11,
    parameter int OFF_W   = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               locked,
    input logic [SPLIT_W-1:0] split_off,
    input logic [5:0]         perms,
    input logic               pending,
    input logic               clr_held,
    input logic               viol,
    input logic               ctrl_wr,
    input logic [OFF_W-1:0]   st_off
);

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R6
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(split_off) && $stable(perms)));

    // R8
    clr_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_held |-> !pending);

    // R9
    record_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> $stable(st_off));

    // R7
    viol_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !clr_held && !ctrl_wr) |=> pending);

endmodule

bind split_perm_mon spm_chk #(
    .SPLIT_W (SPLIT_W),
    .OFF_W   (OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (locked),
    .split_off (split_off),
    .perms     ({hi_perm, lo_perm}),
    .pending   (pending),
    .clr_held  (clr_held),
    .viol      (viol),
    .ctrl_wr   (ctrl_wr),
    .st_off    (st_off)
);

// File: tb/sim_split_perm_mon.sv
`timescale 1ns/1ps
module sim_split_perm_mon;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_fetch = 1'b0;
    logic        acc_sub = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    split_perm_mon u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .acc_fetch (acc_fetch),
        .acc_sub   (acc_sub),
        .irq       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    logic [31:0] got;
    int  total = 0;
    int  fails = 0;
    bit  chk_go = 1'b0;
    bit  done = 1'b0;

    // Monitor: pops one expected item per check cycle.
    always @(negedge clk) begin
        if (chk_go && exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            got = cur.is_irq ? {31'b0, irq} : reg_rdata;
            total++;
            if (got !== cur.exp) begin
                fails++;
                $display("FAIL %s: got 0x%08h expected 0x%08h", cur.tag, got, cur.exp);
            end
        end
    end

    task automatic idle();
        @(posedge clk); #1;
        chk_go = 0; reg_we = 0; acc_valid = 0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(posedge clk); #1;
        chk_go = 0; acc_valid = 0;
        reg_we = 1; reg_sel = s; reg_wdata = d;
    endtask

    task automatic acc(input logic [31:0] a, input logic w, input logic f, input logic sb);
        @(posedge clk); #1;
        chk_go = 0; reg_we = 0;
        acc_valid = 1; acc_addr = a; acc_write = w; acc_fetch = f; acc_sub = sb;
    endtask

    task automatic rd(input logic [1:0] s, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        reg_we = 0; acc_valid = 0; reg_sel = s;
        exp_q.push_back('{1'b0, e, t});
        chk_go = 1;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(posedge clk); #1;
        reg_we = 0; acc_valid = 0;
        exp_q.push_back('{1'b1, {31'b0, e}, t});
        chk_go = 1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        chk_go = 0; reg_we = 0; acc_valid = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10 reset state
        rd(2'd0, 32'h0, "R10 lock after reset");
        rd(2'd1, 32'h3F, "R10 config after reset");
        rd(2'd2, 32'h0, "R10 control after reset");
        chk_irq(1'b0, "R10 irq after reset");

        // R2 all enables set: write anywhere is fine
        acc(32'h1100, 1, 0, 0);
        rd(2'd2, 32'h0, "R2 allowed access after reset");

        // R3 split word 0x100 (byte 0x1400); lower read only, upper read+write
        wr(2'd1, 32'h4019);
        rd(2'd1, 32'h4019, "R3 config readback");

        // R1 outside window edges
        acc(32'h0FFC, 1, 0, 0);
        acc(32'h2000, 1, 0, 0);
        rd(2'd2, 32'h0, "R1 outside window ignored");

        // R1 split boundary: word at split is upper (write allowed)
        acc(32'h1400, 1, 0, 0);
        acc(32'h13FC, 0, 0, 0);
        rd(2'd2, 32'h0, "R1 split word uses upper enables");

        // R7 write to lower region faults with enable off
        acc(32'h13FC, 1, 0, 1);
        rd(2'd2, 32'h4, "R7 pending without enable");
        chk_irq(1'b0, "R7 irq gated by enable");
        rd(2'd3, 32'hC000_03FC, "R9 first record");

        // R9 second violation keeps the first record
        acc(32'h1800, 0, 1, 0);
        rd(2'd3, 32'hC000_03FC, "R9 record held while pending");

        // R7 enable interrupt
        wr(2'd2, 32'h1);
        rd(2'd2, 32'h5, "R7 enable with pending");
        chk_irq(1'b1, "R7 irq asserted");

        // R8 clear held high
        wr(2'd2, 32'h3);
        rd(2'd2, 32'h3, "R8 clear drops pending");
        chk_irq(1'b0, "R8 irq low while clearing");
        acc(32'h1800, 0, 1, 0);
        rd(2'd2, 32'h3, "R8 violation ignored while clear held");
        wr(2'd2, 32'h1);
        rd(2'd2, 32'h1, "R8 clear released");
        acc(32'h1800, 0, 1, 0);
        rd(2'd2, 32'h5, "R8 pending sets again");
        rd(2'd3, 32'h2000_0800, "R2 fetch needs execute, R9 record");

        // R2 read without read enable in lower region
        wr(2'd2, 32'h3);
        wr(2'd2, 32'h1);
        wr(2'd1, 32'h4018);
        acc(32'h1FFC, 0, 0, 0);
        rd(2'd2, 32'h1, "R2 upper read allowed at last word");
        acc(32'h1000, 0, 0, 0);
        rd(2'd2, 32'h5, "R2 lower read denied");
        rd(2'd3, 32'h0, "R9 record of read at window start");

        // R4 split range
        wr(2'd1, 32'h1003F);
        rd(2'd1, 32'h4018, "R4 out-of-range split refused");
        wr(2'd1, 32'hFFFF);
        rd(2'd1, 32'hFFFF, "R4 last word split accepted");

        // R5 lock
        wr(2'd0, 32'h0);
        rd(2'd0, 32'h0, "R5 zero write leaves lock clear");
        wr(2'd0, 32'h1);
        rd(2'd0, 32'h1, "R5 lock set");
        wr(2'd0, 32'h0);
        rd(2'd0, 32'h1, "R5 lock sticky");

        // R6 config frozen, control writable
        wr(2'd1, 32'h3F);
        rd(2'd1, 32'hFFFF, "R6 config write ignored when locked");
        wr(2'd2, 32'h2);
        rd(2'd2, 32'h2, "R6 control writable when locked");
        wr(2'd2, 32'h0);
        rd(2'd2, 32'h0, "R6 control cleared when locked");

        // R10 reset releases lock
        do_reset();
        rd(2'd0, 32'h0, "R10 lock released by reset");
        rd(2'd1, 32'h3F, "R10 config restored by reset");
        idle();
        idle();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule